// File: doc/BRIEF.md
# Circular Self-Test Path Register

This block replaces the plain state register of a sequential circuit with a bank of cells that can also test that circuit. One control line picks the mode. In system mode every cell is an ordinary D flip-flop that loads its functional next-state bit.

In test mode each cell loads its functional bit XORed with the value of the cell before it, and the last cell feeds the first. The whole bank becomes one closed ring. Each clock the ring contents drive the logic as a fresh pattern, while the logic responses are folded back into the ring as a running signature. Pattern generation and response compaction therefore share the same cycles.

A synchronous initialise input loads a fixed seed, so every run produces the same signature. A serial input is injected at one chosen cell, and a serial output is taken from another chosen cell. A built-in counter tracks the test-mode cycles since initialise. After a set number of those cycles it captures the ring and compares the captured value with an expected signature supplied at a port.

Top module: `cstp_reg`

## Requirements
- R1: While reset is active and after it is released, `dout` is 0, `scan_out` is 0, `sig_done` is 0 and `sig_pass` is 0, until the first clock edge that loads new values.
- R2: In system mode (`test_mode`=0) with `init`=0, every bit of `dout` takes the matching bit of `din` at each rising clock edge.
- R3: In test mode (`test_mode`=1) with `init`=0, bit i of `dout` takes `din[i]` XOR the old `dout[i-1]`. Bit 0 takes `din[0]` XOR the old `dout[WIDTH-1]`. With the defaults (WIDTH=8) this is `din ^ {dout[6:0],dout[7]}`.
- R4: In test mode, `scan_in` is also XORed into the next value of cell SCAN_IN_IDX (default bit 0). In system mode, `scan_in` has no effect on `dout`.
- R5: `scan_out` always equals `dout[SCAN_OUT_IDX]`, which is bit 7 by default.
- R6: `init`=1 loads SEED (default 8'h01) into `dout` at the next edge, whatever the mode. It also clears the test-cycle count, so `sig_done` reads 0 after that edge.
- R7: A mode change takes effect at the next clock edge. The register contents carry over unchanged into the first cycle of the new mode.
- R8: `sig_done` becomes 1 after exactly TEST_LEN (default 20) test-mode edges with `init`=0 since the last initialise or reset. System-mode edges do not count. `sig_done` then stays 1 until `init` or reset.
- R9: The ring value produced by the TEST_LEN-th counted edge is held as the signature. `sig_pass` is 1 exactly when `sig_done` is 1 and the held signature equals `golden`. The held signature does not change during later test cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 0 selects system mode, 1 selects test mode |
| init | input | 1 | Synchronous load of the seed and clear of the cycle count |
| din | input | WIDTH | Functional next-state bits from the circuit logic |
| scan_in | input | 1 | Serial input injected at cell SCAN_IN_IDX in test mode |
| golden | input | WIDTH | Expected signature |
| dout | output | WIDTH | Register contents, driven into the circuit logic |
| scan_out | output | 1 | Serial output from cell SCAN_OUT_IDX |
| sig_done | output | 1 | The configured number of test cycles has elapsed |
| sig_pass | output | 1 | Held signature matches `golden` |

## Verification
Every cell drives `dout` directly, so a wrong next-state in any cell appears on the ports one edge after the stimulus that caused it. In test mode it then travels one position around the ring per cycle, so it keeps reappearing on later cycles. A wrong cycle count or a wrong capture instant shows up as `sig_done` rising on the wrong edge. It can also show up as a held signature that disagrees with the ring value computed arithmetically for the TEST_LEN-th counted edge, which `sig_pass` exposes as soon as `golden` is set.

// File: rtl/cstp_pkg.sv
package cstp_pkg;
   typedef enum logic {
      MODE_SYS  = 1'b0,
      MODE_TEST = 1'b1
   } cstp_mode_e;

   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/cstp_cell.sv
module cstp_cell
   import cstp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   input  logic       seed_bit,
   input  cstp_mode_e mode,
   input  logic       func_d,
   input  logic       chain_in,
   input  logic       inject,
   output logic       nxt,
   output logic       q
);
   always_comb begin
      if (init)
         nxt = seed_bit;
      else if (mode == MODE_TEST)
         nxt = func_d ^ chain_in ^ inject;
      else
         nxt = func_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else
         q <= nxt;
   end
endmodule

// File: rtl/cstp_ring.sv
module cstp_ring
   import cstp_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter logic [WIDTH-1:0] SEED   = WIDTH'(1),
   parameter int unsigned SCAN_IN_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  cstp_mode_e       mode,
   input  logic [WIDTH-1:0] func_d,
   input  logic             scan_in,
   output logic [WIDTH-1:0] ring_nxt,
   output logic [WIDTH-1:0] ring_q
);
   localparam int unsigned LAST = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      logic chain;
      logic inj;

      if (i == 0) begin : g_wrap
         assign chain = ring_q[LAST];
      end else begin : g_link
         assign chain = ring_q[i-1];
      end

      if (i == SCAN_IN_IDX) begin : g_inject
         assign inj = scan_in;
      end else begin : g_plain
         assign inj = 1'b0;
      end

      cstp_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .init     (init),
         .seed_bit (SEED[i]),
         .mode     (mode),
         .func_d   (func_d[i]),
         .chain_in (chain),
         .inject   (inj),
         .nxt      (ring_nxt[i]),
         .q        (ring_q[i])
      );
   end
endmodule

// File: rtl/cstp_sig_ctrl.sv
module cstp_sig_ctrl
   import cstp_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter int unsigned TEST_LEN = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  cstp_mode_e       mode,
   input  logic [WIDTH-1:0] ring_nxt,
   input  logic [WIDTH-1:0] golden,
   output logic             done,
   output logic             pass
);
   localparam int unsigned CW = cnt_bits(TEST_LEN);
   localparam logic [CW-1:0] LIMIT    = CW'(TEST_LEN);
   localparam logic [CW-1:0] LAST_CNT = CW'(TEST_LEN - 1);

   logic [CW-1:0]    cnt;
   logic [WIDTH-1:0] sig_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sig_hold <= '0;
      end else if (init) begin
         cnt <= '0;
      end else if (mode == MODE_TEST && cnt != LIMIT) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST_CNT)
            sig_hold <= ring_nxt;
      end
   end

   assign done = (cnt == LIMIT);
   assign pass = done && (sig_hold == golden);
endmodule

// File: rtl/cstp_reg.sv
module cstp_reg
   import cstp_pkg::*;
#(
   parameter int unsigned WIDTH        = 8,
   parameter logic [WIDTH-1:0] SEED    = WIDTH'(1),
   parameter int unsigned SCAN_IN_IDX  = 0,
   parameter int unsigned SCAN_OUT_IDX = WIDTH - 1,
   parameter int unsigned TEST_LEN     = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             test_mode,
   input  logic             init,
   input  logic [WIDTH-1:0] din,
   input  logic             scan_in,
   input  logic [WIDTH-1:0] golden,
   output logic [WIDTH-1:0] dout,
   output logic             scan_out,
   output logic             sig_done,
   output logic             sig_pass
);
   if (WIDTH < 2) begin : g_bad_width
      $error("cstp_reg: WIDTH must be at least 2");
   end
   if (SCAN_IN_IDX >= WIDTH) begin : g_bad_si
      $error("cstp_reg: SCAN_IN_IDX out of range");
   end
   if (SCAN_OUT_IDX >= WIDTH) begin : g_bad_so
      $error("cstp_reg: SCAN_OUT_IDX out of range");
   end
   if (TEST_LEN < 1) begin : g_bad_len
      $error("cstp_reg: TEST_LEN must be at least 1");
   end

   cstp_mode_e       mode;
   logic [WIDTH-1:0] ring_nxt;

   assign mode = test_mode ? MODE_TEST : MODE_SYS;

   cstp_ring #(
      .WIDTH       (WIDTH),
      .SEED        (SEED),
      .SCAN_IN_IDX (SCAN_IN_IDX)
   ) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (init),
      .mode     (mode),
      .func_d   (din),
      .scan_in  (scan_in),
      .ring_nxt (ring_nxt),
      .ring_q   (dout)
   );

   cstp_sig_ctrl #(
      .WIDTH    (WIDTH),
      .TEST_LEN (TEST_LEN)
   ) u_sig (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (init),
      .mode     (mode),
      .ring_nxt (ring_nxt),
      .golden   (golden),
      .done     (sig_done),
      .pass     (sig_pass)
   );

   assign scan_out = dout[SCAN_OUT_IDX];
endmodule

// File: rtl/cstp_reg_chk.sv
module cstp_reg_chk #(
   parameter int unsigned WIDTH        = 8,
   parameter logic [WIDTH-1:0] SEED    = WIDTH'(1),
   parameter int unsigned SCAN_IN_IDX  = 0,
   parameter int unsigned SCAN_OUT_IDX = WIDTH - 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             test_mode,
   input logic             init,
   input logic [WIDTH-1:0] din,
   input logic             scan_in,
   input logic [WIDTH-1:0] dout,
   input logic             scan_out,
   input logic             sig_done,
   input logic             sig_pass
);
   function automatic logic [WIDTH-1:0] rot(input logic [WIDTH-1:0] v);
      return {v[WIDTH-2:0], v[WIDTH-1]};
   endfunction

   function automatic logic [WIDTH-1:0] inj(input logic b);
      return WIDTH'(b) << SCAN_IN_IDX;
   endfunction

   assert_sys_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !init) |=> dout == $past(din));

   assert_ring_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !init) |=> dout == ($past(din) ^ rot($past(dout)) ^ inj($past(scan_in))));

   assert_scan_tap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      scan_out == dout[SCAN_OUT_IDX]);

   assert_seed_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (dout == SEED) && !sig_done);

   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_done && !init) |=> sig_done);

   assert_pass_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sig_pass |-> sig_done);
endmodule

bind cstp_reg cstp_reg_chk #(
   .WIDTH        (WIDTH),
   .SEED         (SEED),
   .SCAN_IN_IDX  (SCAN_IN_IDX),
   .SCAN_OUT_IDX (SCAN_OUT_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .test_mode (test_mode),
   .init      (init),
   .din       (din),
   .scan_in   (scan_in),
   .dout      (dout),
   .scan_out  (scan_out),
   .sig_done  (sig_done),
   .sig_pass  (sig_pass)
);

// File: tb/cstp_reg_test.sv
module cstp_reg_test;
   localparam int TLEN = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       test_mode = 1'b0;
   logic       init = 1'b0;
   logic [7:0] din = '0;
   logic       scan_in = 1'b0;
   logic [7:0] golden = '0;
   logic [7:0] dout;
   logic       scan_out;
   logic       sig_done;
   logic       sig_pass;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [7:0] m_q = '0;
   int         m_cnt = 0;
   logic [7:0] m_sig = '0;

   always #5 clk = ~clk;

   cstp_reg uut (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .init(init),
      .din(din), .scan_in(scan_in), .golden(golden), .dout(dout),
      .scan_out(scan_out), .sig_done(sig_done), .sig_pass(sig_pass)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input string req, input logic tm, input logic in_i,
                       input logic [7:0] d, input logic si);
      logic [7:0] nx;
      test_mode = tm; init = in_i; din = d; scan_in = si;
      if (in_i) nx = 8'h01;
      else if (tm) nx = d ^ {m_q[6:0], m_q[7]} ^ {7'b0, si};
      else nx = d;
      @(posedge clk);
      @(negedge clk);
      if (in_i) m_cnt = 0;
      else if (tm && m_cnt < TLEN) begin
         if (m_cnt == TLEN - 1) m_sig = nx;
         m_cnt++;
      end
      m_q = nx;
      chk(req, dout, m_q);
      chk("R5", scan_out, m_q[7]);
      chk("R8", sig_done, m_cnt == TLEN);
      chk("R9", sig_pass, (m_cnt == TLEN) && (m_sig == golden));
   endtask

   initial begin
      #1500000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      chk("R1", dout, 0); chk("R1", scan_out, 0);
      chk("R1", sig_done, 0); chk("R1", sig_pass, 0);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1", dout, 0); chk("R1", sig_done, 0);

      step("R6", 1'b0, 1'b1, 8'hA5, 1'b1);

      // R2 and R4: system mode over every din value, scan_in toggling
      for (int v = 0; v < 256; v++)
         step("R2_R4_sys", 1'b0, 1'b0, 8'(v), v[0]);

      // R3: pure rotation of the seed
      step("R6", 1'b1, 1'b1, 8'h00, 1'b0);
      for (int k = 0; k < 10; k++)
         step("R3_rot", 1'b1, 1'b0, 8'h00, 1'b0);

      // R3, R4, R7: mixed modes and data, ring state carried across switches
      for (int v = 0; v < 256; v++) begin
         logic [7:0] d;
         d = 8'(v * 37) ^ 8'(v >> 3);
         step("R3_R4_R7_mix", v[1] ^ v[4], 1'b0, d, v[2] ^ v[5]);
      end

      // R8: system cycles do not count
      step("R6", 1'b1, 1'b1, 8'h3C, 1'b0);
      chk("R6", sig_done, 0);
      for (int k = 0; k < 10; k++) step("R8_a", 1'b1, 1'b0, 8'(k * 11), 1'b1);
      for (int k = 0; k < 5; k++)  step("R8_sys", 1'b0, 1'b0, 8'(k + 7), 1'b0);
      for (int k = 0; k < 9; k++)  step("R8_b", 1'b1, 1'b0, 8'(k * 5), k[0]);
      chk("R8", sig_done, 0);
      step("R8_last", 1'b1, 1'b0, 8'h5A, 1'b1);
      chk("R8", sig_done, 1);

      // R9: compare against golden
      golden = m_sig; #1;
      chk("R9", sig_pass, 1);
      golden = m_sig ^ 8'h10; #1;
      chk("R9", sig_pass, 0);
      golden = m_sig;
      for (int k = 0; k < 6; k++) step("R9_hold", 1'b1, 1'b0, 8'(k * 29), 1'b1);
      chk("R9", sig_pass, 1);
      step("R6", 1'b0, 1'b1, 8'h00, 1'b0);
      chk("R6", sig_done, 0);
      chk("R6", dout, 8'h01);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule